// File: doc/BRIEF.md
# Dual-Access Shared Memory Controller

This controller sits on a processor board that owns a block of common memory. Two kinds of master can reach that memory: the processor on the same board, and any other master on the shared system bus. The local processor can also reach common memory that sits on other boards. The controller looks at the upper address bits on each side and turns them into three kinds of request. Internal is the local processor using its own memory. Communication is the local processor going out to a remote board. External is a bus master coming in to this board's memory. A synchronous state machine then grants exactly one of them at a time.

Every granted access takes a fixed slot of two clock cycles. From the grant and the transfer direction the controller produces the memory strobes (chip select, output enable, write enable), the memory address and write-data steering, and the enables for the local buffer, the bus-side buffer and the outgoing bus drivers. It also produces the direction of the bus data buffers, a one-cycle ready pulse for the local processor, and a one-cycle acknowledge pulse for the bus master.

Local and incoming accesses to the same memory are interleaved one word at a time. An incoming master is held off while a local word is in progress. A local lock input keeps incoming masters out entirely for as long as it is held.

Top module: `shmem_access_ctrl`

## Requirements
- R1: While reset is low, and on the first cycle after it is released, all grants, memory strobes, buffer enables, drv_dir, bus_req, loc_rdy and bus_xack are low.
- R2: A local read or write whose top SEL_W address bits equal OWN_SEL is an internal request. Any other local read or write is a communication request. A bus read or write whose top SEL_W bits equal OWN_SEL is an external request. Bus cycles to any other region get no grant and no acknowledge.
- R3: At most one of gnt_int, gnt_ext and gnt_com is high in any cycle.
- R4: A request seen at a clock edge while the controller is idle raises its grant in the next cycle. The grant lasts exactly two cycles. The ready pulse (loc_rdy for internal or communication) or the acknowledge pulse (bus_xack for external) is high for one cycle only, in the second cycle.
- R5: If internal and external requests appear in the same cycle while the controller is idle, the internal word is served first. The external word starts in the very next cycle after the internal slot ends.
- R6: An external request that arrives during an internal slot waits until that slot ends. bus_xack stays low for the whole wait, and the external slot follows immediately after.
- R7: While internal and external requests are both held continuously, the grants alternate one word at a time: internal, external, internal, and so on.
- R8: While loc_lock is high, no external slot starts and bus_xack stays low. Once the lock is released, the pending external request is served.
- R9: A communication request raises bus_req and waits until bus_granted is high before gnt_com rises. While it waits, an external request is served first, and the communication request resumes waiting afterwards. bus_req is high in the waiting and communication cycles. mem_cs stays low during communication.
- R10: mem_cs is high during internal and external slots. mem_oe is high in both cycles of a read slot. mem_we is high only in the second cycle of a write slot. mem_addr and mem_wdata come from the low address bits and the write data of the granted side.
- R11: int_buf_en follows gnt_int, ext_buf_en follows gnt_ext and com_drv_en follows gnt_com. drv_dir (1 = this board drives the bus data lines) is high only during an external read or a communication write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| loc_rd | input | 1 | Local processor read request, held until loc_rdy |
| loc_wr | input | 1 | Local processor write request, held until loc_rdy |
| loc_addr | input | AW | Local processor address |
| loc_wdata | input | DW | Local processor write data |
| loc_lock | input | 1 | Local lock; blocks incoming access |
| loc_rdy | output | 1 | One-cycle ready pulse to the local processor |
| bus_rd | input | 1 | Bus master read request, held until bus_xack |
| bus_wr | input | 1 | Bus master write request, held until bus_xack |
| bus_addr | input | AW | System bus address |
| bus_wdata | input | DW | System bus write data |
| bus_xack | output | 1 | One-cycle transfer acknowledge to the bus master |
| bus_req | output | 1 | Request for the system bus |
| bus_granted | input | 1 | System bus granted to this board |
| gnt_int | output | 1 | Internal access granted |
| gnt_ext | output | 1 | External access granted |
| gnt_com | output | 1 | Communication access granted |
| mem_cs | output | 1 | Common memory chip select |
| mem_oe | output | 1 | Common memory output enable |
| mem_we | output | 1 | Common memory write enable |
| mem_addr | output | AW-SEL_W | Common memory word address |
| mem_wdata | output | DW | Common memory write data |
| int_buf_en | output | 1 | Local-side data/address buffer enable |
| ext_buf_en | output | 1 | Bus-side buffer enable for incoming access |
| com_drv_en | output | 1 | Outgoing bus address/data driver enable |
| drv_dir | output | 1 | Bus data buffer direction, 1 = toward bus |

## Verification
Some properties are checked on every cycle. These are that the grants never overlap, that a slot once begun runs to completion, that the acknowledge and ready pulses last one cycle and fall in the second cycle of a slot, and that write enable appears only after chip select has been held for one cycle. They also cover that no incoming slot starts while the lock is held, that a communication slot starts only with the bus granted, and that an internal word with an incoming request waiting is followed at once by the incoming word. Other behaviours can only be shown by the bench's directed scenarios. These are the exact latency from request to grant, the priority when both sides arrive together, the wait and later service of a locked-out master, the word-by-word alternation pattern, incoming service while a communication waits for the bus, and the steering of address, data and direction.

// File: rtl/smc_pkg.sv
// Shared types for the shared memory access controller.
// Assumes: one local master and one bus-side path per board.
package smc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_INT_A,
        ST_INT_B,
        ST_EXT_A,
        ST_EXT_B,
        ST_COM_W,
        ST_COM_A,
        ST_COM_B
    } smc_state_e;

    typedef enum logic [1:0] {
        GR_NONE,
        GR_INT,
        GR_EXT,
        GR_COM
    } smc_grant_e;

    typedef struct packed {
        logic int_req;
        logic com_req;
        logic ext_req;
    } smc_req_t;

endpackage

// File: rtl/smc_req_decode.sv
// Request decoder: turns the region-select bits of the local and bus
// addresses into internal, communication and external requests.
// Assumes: a read and a write are never requested together by one side.
module smc_req_decode
    import smc_pkg::*;
#(
    parameter int               SEL_W   = 4,
    parameter logic [SEL_W-1:0] OWN_SEL = 4'hA
) (
    input  logic             loc_rd,
    input  logic             loc_wr,
    input  logic [SEL_W-1:0] loc_sel,
    input  logic             bus_rd,
    input  logic             bus_wr,
    input  logic [SEL_W-1:0] bus_sel,
    output smc_req_t         req
);

    logic loc_hit;
    logic bus_hit;

    // Compare each side's region select against this board's region.
    always_comb begin
        loc_hit = (loc_sel == OWN_SEL);
        bus_hit = (bus_sel == OWN_SEL);
    end

    // Classify the active cycles into the three request kinds.
    always_comb begin
        req.int_req = (loc_rd | loc_wr) &  loc_hit;
        req.com_req = (loc_rd | loc_wr) & ~loc_hit;
        req.ext_req = (bus_rd | bus_wr) &  bus_hit;
    end

endmodule

// File: rtl/smc_access_fsm.sv
// Access sequencer: grants one access at a time in fixed two-cycle slots,
// interleaves internal and external words, honours the local lock and
// waits for the bus grant before a communication slot.
// Assumes: each requester holds its request until its ready/acknowledge.
module smc_access_fsm
    import smc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  smc_req_t   req,
    input  logic       loc_lock,
    input  logic       bus_granted,
    output smc_grant_e grant,
    output logic       phase_b,
    output logic       bus_req
);

    smc_state_e state;
    smc_state_e state_nx;
    logic       ext_ok;

    // An incoming request may be served only when the lock is released.
    always_comb ext_ok = req.ext_req & ~loc_lock;

    // Next-state selection; a slot just served is not reconsidered.
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (req.int_req)      state_nx = ST_INT_A;
                else if (ext_ok)      state_nx = ST_EXT_A;
                else if (req.com_req) state_nx = ST_COM_W;
            end
            ST_INT_A: state_nx = ST_INT_B;
            ST_INT_B: state_nx = ext_ok ? ST_EXT_A : ST_IDLE;
            ST_EXT_A: state_nx = ST_EXT_B;
            ST_EXT_B: begin
                if (req.int_req)      state_nx = ST_INT_A;
                else if (req.com_req) state_nx = ST_COM_W;
                else                  state_nx = ST_IDLE;
            end
            ST_COM_W: begin
                if (!req.com_req)     state_nx = ST_IDLE;
                else if (bus_granted) state_nx = ST_COM_A;
                else if (ext_ok)      state_nx = ST_EXT_A;
            end
            ST_COM_A: state_nx = ST_COM_B;
            ST_COM_B: state_nx = ext_ok ? ST_EXT_A : ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // State register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Decode the current state into grant, slot phase and bus request.
    always_comb begin
        grant   = GR_NONE;
        phase_b = 1'b0;
        bus_req = 1'b0;
        unique case (state)
            ST_INT_A: grant = GR_INT;
            ST_INT_B: begin grant = GR_INT; phase_b = 1'b1; end
            ST_EXT_A: grant = GR_EXT;
            ST_EXT_B: begin grant = GR_EXT; phase_b = 1'b1; end
            ST_COM_W: bus_req = 1'b1;
            ST_COM_A: begin grant = GR_COM; bus_req = 1'b1; end
            ST_COM_B: begin grant = GR_COM; bus_req = 1'b1; phase_b = 1'b1; end
            default: ;
        endcase
    end

endmodule

// File: rtl/smc_strobe_gen.sv
// Strobe generator: turns the active grant and slot phase into memory
// strobes, buffer enables, bus direction, handshake pulses and the
// address and write-data steering.
// Assumes: the granted side keeps address, data and direction stable.
module smc_strobe_gen
    import smc_pkg::*;
#(
    parameter int MAW = 12,
    parameter int DW  = 16
) (
    input  smc_grant_e     grant,
    input  logic           phase_b,
    input  logic           loc_wr,
    input  logic           bus_wr,
    input  logic [MAW-1:0] loc_word,
    input  logic [MAW-1:0] bus_word,
    input  logic [DW-1:0]  loc_wdata,
    input  logic [DW-1:0]  bus_wdata,
    output logic           gnt_int,
    output logic           gnt_ext,
    output logic           gnt_com,
    output logic           mem_cs,
    output logic           mem_oe,
    output logic           mem_we,
    output logic [MAW-1:0] mem_addr,
    output logic [DW-1:0]  mem_wdata,
    output logic           int_buf_en,
    output logic           ext_buf_en,
    output logic           com_drv_en,
    output logic           drv_dir,
    output logic           loc_rdy,
    output logic           bus_xack
);

    logic slot_wr;

    // Expand the grant code into individual grant lines.
    always_comb begin
        gnt_int = (grant == GR_INT);
        gnt_ext = (grant == GR_EXT);
        gnt_com = (grant == GR_COM);
    end

    // Pick the direction of the slot from the side that owns it.
    always_comb slot_wr = gnt_ext ? bus_wr : loc_wr;

    // Memory strobes: write enable only in the second cycle of a slot.
    always_comb begin
        mem_cs = gnt_int | gnt_ext;
        mem_oe = mem_cs & ~slot_wr;
        mem_we = mem_cs & slot_wr & phase_b;
    end

    // Steer address and write data from the side that owns the memory.
    always_comb begin
        mem_addr  = gnt_ext ? bus_word  : loc_word;
        mem_wdata = gnt_ext ? bus_wdata : loc_wdata;
    end

    // Buffer enables and bus data direction.
    always_comb begin
        int_buf_en = gnt_int;
        ext_buf_en = gnt_ext;
        com_drv_en = gnt_com;
        drv_dir    = (gnt_ext & ~bus_wr) | (gnt_com & loc_wr);
    end

    // Handshake pulses in the closing cycle of each slot.
    always_comb begin
        loc_rdy  = phase_b & (gnt_int | gnt_com);
        bus_xack = phase_b & gnt_ext;
    end

endmodule

// File: rtl/shmem_access_ctrl.sv
// Top of the shared memory access controller: decoder, sequencer and
// strobe generator. Arbitration, memory array and remote boards are
// external; they are seen only through the ports.
// Assumes: synchronous active-low reset, single clock domain.
module shmem_access_ctrl
    import smc_pkg::*;
#(
    parameter int               AW      = 16,
    parameter int               DW      = 16,
    parameter int               SEL_W   = 4,
    parameter logic [SEL_W-1:0] OWN_SEL = 4'hA,
    localparam int              MAW     = AW - SEL_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           loc_rd,
    input  logic           loc_wr,
    input  logic [AW-1:0]  loc_addr,
    input  logic [DW-1:0]  loc_wdata,
    input  logic           loc_lock,
    output logic           loc_rdy,
    input  logic           bus_rd,
    input  logic           bus_wr,
    input  logic [AW-1:0]  bus_addr,
    input  logic [DW-1:0]  bus_wdata,
    output logic           bus_xack,
    output logic           bus_req,
    input  logic           bus_granted,
    output logic           gnt_int,
    output logic           gnt_ext,
    output logic           gnt_com,
    output logic           mem_cs,
    output logic           mem_oe,
    output logic           mem_we,
    output logic [MAW-1:0] mem_addr,
    output logic [DW-1:0]  mem_wdata,
    output logic           int_buf_en,
    output logic           ext_buf_en,
    output logic           com_drv_en,
    output logic           drv_dir
);

    smc_req_t   req;
    smc_grant_e grant;
    logic       phase_b;

    smc_req_decode #(
        .SEL_W   (SEL_W),
        .OWN_SEL (OWN_SEL)
    ) u_decode (
        .loc_rd  (loc_rd),
        .loc_wr  (loc_wr),
        .loc_sel (loc_addr[AW-1:MAW]),
        .bus_rd  (bus_rd),
        .bus_wr  (bus_wr),
        .bus_sel (bus_addr[AW-1:MAW]),
        .req     (req)
    );

    smc_access_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .req         (req),
        .loc_lock    (loc_lock),
        .bus_granted (bus_granted),
        .grant       (grant),
        .phase_b     (phase_b),
        .bus_req     (bus_req)
    );

    smc_strobe_gen #(
        .MAW (MAW),
        .DW  (DW)
    ) u_strobe (
        .grant      (grant),
        .phase_b    (phase_b),
        .loc_wr     (loc_wr),
        .bus_wr     (bus_wr),
        .loc_word   (loc_addr[MAW-1:0]),
        .bus_word   (bus_addr[MAW-1:0]),
        .loc_wdata  (loc_wdata),
        .bus_wdata  (bus_wdata),
        .gnt_int    (gnt_int),
        .gnt_ext    (gnt_ext),
        .gnt_com    (gnt_com),
        .mem_cs     (mem_cs),
        .mem_oe     (mem_oe),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .int_buf_en (int_buf_en),
        .ext_buf_en (ext_buf_en),
        .com_drv_en (com_drv_en),
        .drv_dir    (drv_dir),
        .loc_rdy    (loc_rdy),
        .bus_xack   (bus_xack)
    );

endmodule

// File: rtl/shmem_access_ctrl_chk.sv
// Property checker for the shared memory access controller, bound to the
// top module. Observes ports only.
module shmem_access_ctrl_chk #(
    parameter int               AW      = 16,
    parameter int               SEL_W   = 4,
    parameter logic [SEL_W-1:0] OWN_SEL = 4'hA
) (
    input logic          clk,
    input logic          rst_n,
    input logic          loc_lock,
    input logic          loc_rdy,
    input logic          bus_rd,
    input logic          bus_wr,
    input logic [AW-1:0] bus_addr,
    input logic          bus_xack,
    input logic          bus_granted,
    input logic          gnt_int,
    input logic          gnt_ext,
    input logic          gnt_com,
    input logic          mem_cs,
    input logic          mem_we
);

    // R1: a reset cycle leaves every grant low on the following cycle.
    p_reset_idle_r1: assert property (@(posedge clk)
        !rst_n |=> !(gnt_int | gnt_ext | gnt_com | loc_rdy | bus_xack));

    // R3: grants never overlap.
    p_grant_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({gnt_int, gnt_ext, gnt_com}));

    // R4: acknowledge is a single-cycle pulse ending an external slot.
    p_xack_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        bus_xack |=> !bus_xack);

    p_xack_second_r4: assert property (@(posedge clk) disable iff (!rst_n)
        bus_xack |-> (gnt_ext && $past(gnt_ext)));

    p_rdy_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        loc_rdy |=> !loc_rdy);

    // R6: an internal slot is never cut short by an external request.
    p_int_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_int && !loc_rdy) |=> gnt_int);

    // R7: a waiting unlocked external word follows an internal word.
    p_alternate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_int && loc_rdy && (bus_rd || bus_wr) && !loc_lock
         && (bus_addr[AW-1:AW-SEL_W] == OWN_SEL)) |=> gnt_ext);

    // R8: no external slot starts while the lock is held.
    p_lock_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!gnt_ext && loc_lock) |=> !gnt_ext);

    // R9: a communication slot only starts with the bus granted.
    p_com_granted_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gnt_com) |-> $past(bus_granted));

    // R10: write enable only after chip select has been held a cycle.
    p_we_late_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_cs && $past(mem_cs)));

endmodule

bind shmem_access_ctrl shmem_access_ctrl_chk #(
    .AW      (AW),
    .SEL_W   (SEL_W),
    .OWN_SEL (OWN_SEL)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .loc_lock    (loc_lock),
    .loc_rdy     (loc_rdy),
    .bus_rd      (bus_rd),
    .bus_wr      (bus_wr),
    .bus_addr    (bus_addr),
    .bus_xack    (bus_xack),
    .bus_granted (bus_granted),
    .gnt_int     (gnt_int),
    .gnt_ext     (gnt_ext),
    .gnt_com     (gnt_com),
    .mem_cs      (mem_cs),
    .mem_we      (mem_we)
);

// File: tb/tb_shmem_access_ctrl.sv
// Directed bench: inputs change and outputs are sampled on the falling edge.
module tb_shmem_access_ctrl;

    localparam int AW  = 16;
    localparam int DW  = 16;
    localparam int MAW = 12;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           loc_rd = 1'b0, loc_wr = 1'b0, loc_lock = 1'b0;
    logic [AW-1:0]  loc_addr = '0;
    logic [DW-1:0]  loc_wdata = '0;
    logic           bus_rd = 1'b0, bus_wr = 1'b0, bus_granted = 1'b0;
    logic [AW-1:0]  bus_addr = '0;
    logic [DW-1:0]  bus_wdata = '0;
    logic           loc_rdy, bus_xack, bus_req;
    logic           gnt_int, gnt_ext, gnt_com;
    logic           mem_cs, mem_oe, mem_we;
    logic [MAW-1:0] mem_addr;
    logic [DW-1:0]  mem_wdata;
    logic           int_buf_en, ext_buf_en, com_drv_en, drv_dir;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    shmem_access_ctrl dut (
        .clk(clk), .rst_n(rst_n),
        .loc_rd(loc_rd), .loc_wr(loc_wr), .loc_addr(loc_addr),
        .loc_wdata(loc_wdata), .loc_lock(loc_lock), .loc_rdy(loc_rdy),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_xack(bus_xack), .bus_req(bus_req),
        .bus_granted(bus_granted),
        .gnt_int(gnt_int), .gnt_ext(gnt_ext), .gnt_com(gnt_com),
        .mem_cs(mem_cs), .mem_oe(mem_oe), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .int_buf_en(int_buf_en), .ext_buf_en(ext_buf_en),
        .com_drv_en(com_drv_en), .drv_dir(drv_dir)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    function automatic logic [2:0] grants();
        return {gnt_int, gnt_ext, gnt_com};
    endfunction

    function automatic logic [10:0] all_out();
        return {gnt_int, gnt_ext, gnt_com, mem_cs, mem_oe, mem_we,
                int_buf_en, ext_buf_en, com_drv_en, drv_dir, bus_req};
    endfunction

    task automatic idle_inputs();
        loc_rd = 0; loc_wr = 0; bus_rd = 0; bus_wr = 0;
        loc_lock = 0; bus_granted = 0;
    endtask

    task automatic t_reset();
        rst_n = 0;
        step(); step();
        check("R1 outputs in reset", {21'd0, all_out()}, 32'd0);
        check("R1 handshakes in reset", {30'd0, loc_rdy, bus_xack}, 32'd0);
        rst_n = 1;
        step();
        check("R1 idle after reset", {21'd0, all_out()}, 32'd0);
    endtask

    task automatic t_int_read();
        loc_addr = 16'hA123; loc_rd = 1;
        step();
        check("R4 int grant cycle 1", {29'd0, grants()}, 32'b100);
        check("R4 no rdy cycle 1", {31'd0, loc_rdy}, 32'd0);
        check("R10 read strobes", {29'd0, mem_cs, mem_oe, mem_we}, 32'b110);
        check("R10 int address", {20'd0, mem_addr}, 32'h123);
        check("R11 int buffer", {29'd0, int_buf_en, ext_buf_en, drv_dir}, 32'b100);
        step();
        check("R4 rdy in cycle 2", {30'd0, gnt_int, loc_rdy}, 32'b11);
        loc_rd = 0;
        step();
        check("R4 slot over", {21'd0, all_out()}, 32'd0);
    endtask

    task automatic t_int_write();
        loc_addr = 16'hA0F0; loc_wdata = 16'hBEEF; loc_wr = 1;
        step();
        check("R10 no we cycle 1", {29'd0, mem_cs, mem_oe, mem_we}, 32'b100);
        check("R10 int wdata", {16'd0, mem_wdata}, 32'hBEEF);
        step();
        check("R10 we cycle 2", {29'd0, mem_cs, mem_oe, mem_we}, 32'b101);
        loc_wr = 0;
        step();
    endtask

    task automatic t_simultaneous();
        loc_addr = 16'hA001; loc_rd = 1;
        bus_addr = 16'hA777; bus_rd = 1;
        step();
        check("R5 internal first", {29'd0, grants()}, 32'b100);
        check("R5 no xack", {31'd0, bus_xack}, 32'd0);
        step();
        check("R5 internal rdy", {31'd0, loc_rdy}, 32'd1);
        loc_rd = 0;
        step();
        check("R5 external next", {29'd0, grants()}, 32'b010);
        check("R10 ext address", {20'd0, mem_addr}, 32'h777);
        check("R11 ext read dir", {29'd0, ext_buf_en, mem_oe, drv_dir}, 32'b111);
        step();
        check("R4 xack cycle 2", {31'd0, bus_xack}, 32'd1);
        bus_rd = 0;
        step();
        check("R4 xack one cycle", {31'd0, bus_xack}, 32'd0);
    endtask

    task automatic t_ext_during_int();
        loc_addr = 16'hA010; loc_wr = 1;
        step();
        bus_addr = 16'hA020; bus_wdata = 16'h1234; bus_wr = 1;
        check("R6 int running", {29'd0, grants()}, 32'b100);
        step();
        check("R6 ext stalled xack", {30'd0, gnt_ext, bus_xack}, 32'd0);
        loc_wr = 0;
        step();
        check("R6 ext served after", {29'd0, grants()}, 32'b010);
        check("R6 no xack yet", {31'd0, bus_xack}, 32'd0);
        check("R10 ext wdata", {16'd0, mem_wdata}, 32'h1234);
        check("R11 ext write dir", {31'd0, drv_dir}, 32'd0);
        step();
        check("R10 ext we", {30'd0, mem_we, bus_xack}, 32'b11);
        bus_wr = 0;
        step();
    endtask

    task automatic t_alternate();
        logic [2:0] exp;
        loc_addr = 16'hA100; loc_rd = 1;
        bus_addr = 16'hA200; bus_rd = 1;
        for (int i = 0; i < 8; i++) begin
            step();
            exp = ((i / 2) % 2 == 0) ? 3'b100 : 3'b010;
            check("R7 alternation", {29'd0, grants()}, {29'd0, exp});
        end
        loc_rd = 0; bus_rd = 0;
        step(); step(); step();
    endtask

    task automatic t_lock();
        loc_lock = 1;
        bus_addr = 16'hA300; bus_rd = 1;
        for (int i = 0; i < 4; i++) begin
            step();
            check("R8 locked out", {30'd0, gnt_ext, bus_xack}, 32'd0);
        end
        loc_lock = 0;
        step();
        check("R8 served after unlock", {29'd0, grants()}, 32'b010);
        step();
        check("R8 xack after unlock", {31'd0, bus_xack}, 32'd1);
        bus_rd = 0;
        step();
    endtask

    task automatic t_foreign_bus();
        bus_addr = 16'h5300; bus_wr = 1;
        for (int i = 0; i < 3; i++) begin
            step();
            check("R2 foreign bus ignored", {29'd0, mem_cs, gnt_ext, bus_xack}, 32'd0);
        end
        bus_wr = 0;
        step();
    endtask

    task automatic t_comm();
        loc_addr = 16'h3456; loc_wdata = 16'hCAFE; loc_wr = 1;
        step();
        check("R9 bus_req waiting", {30'd0, bus_req, gnt_com}, 32'b10);
        check("R2 foreign local not internal", {31'd0, gnt_int}, 32'd0);
        bus_addr = 16'hA400; bus_rd = 1;
        step();
        check("R9 ext served while waiting", {29'd0, grants()}, 32'b010);
        step();
        check("R9 ext xack while waiting", {31'd0, bus_xack}, 32'd1);
        bus_rd = 0;
        step();
        check("R9 back to waiting", {30'd0, bus_req, gnt_com}, 32'b10);
        step();
        check("R9 still waiting", {30'd0, bus_req, gnt_com}, 32'b10);
        bus_granted = 1;
        step();
        check("R9 comm granted", {29'd0, grants()}, 32'b001);
        check("R11 comm drivers", {29'd0, com_drv_en, drv_dir, mem_cs}, 32'b110);
        step();
        check("R9 comm rdy", {30'd0, loc_rdy, bus_req}, 32'b11);
        loc_wr = 0;
        step();
        bus_granted = 0;
        check("R9 comm done", {30'd0, bus_req, gnt_com}, 32'd0);
    endtask

    task automatic t_reset_mid();
        loc_addr = 16'hA555; loc_rd = 1;
        step();
        rst_n = 0;
        loc_rd = 0;
        step();
        check("R1 reset aborts slot", {21'd0, all_out()}, 32'd0);
        rst_n = 1;
        step();
        check("R1 idle after re-reset", {29'd0, grants()}, 32'd0);
    endtask

    initial begin
        idle_inputs();
        t_reset();
        t_int_read();
        t_int_write();
        t_simultaneous();
        t_ext_during_int();
        t_alternate();
        t_lock();
        t_foreign_bus();
        t_comm();
        t_reset_mid();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule